// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards a small microcontroller against runaway software. It stays idle after any hardware reset. Software arms it by writing a fixed two-byte key to one write-only address on a simple register write bus (address, data, strobe). Once armed, it counts machine-cycle ticks through a selectable power-of-two prescaler into a 14-bit counter. Software must repeat the same key often enough to restart the count. If the count reaches its ceiling, the block drives an active-high system reset pulse of fixed length. No write can disarm it. Only a hardware reset or its own timeout pulse returns it to the idle state.

The key value and the timeout count cannot be read back. All the pins are plain control pins. The write bus has no back-pressure, so a strobe is taken in the cycle it is presented. The tick input marks machine cycles and is sampled on each rising clock edge. The reset pulse is timed in clock cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst_n` is low (asynchronous) and after it is released, `sys_rst` is low and the watchdog is disarmed. No pulse ever appears unless the watchdog has been armed.
- R2: The watchdog arms at the clock edge where a write of 0xE1 to address 0xA6 is taken, provided the previous write to 0xA6 was 0x1E. Writes to other addresses neither arm it nor disturb a pending 0x1E. Any other value written to 0xA6 cancels a pending 0x1E, and 0xE1 without a pending 0x1E does nothing.
- R3: Once armed, the watchdog stays armed. No write of any value to any address disarms it.
- R4: While armed, the 14-bit counter advances by one per prescaler step, and steps occur only on cycles with `tick` high. `sys_rst` rises on the edge after the counter reaches 0x3FFF. With `tick` held high, that edge comes 16383·2^n + 1 edges after the edge that accepted the key. Each cycle with `tick` low adds one edge.
- R5: A key sequence accepted while armed (a service) clears both the counter and the prescaler at the accepting edge. The timeout is then measured again from that edge.
- R6: `presc_sel` is a 3-bit value n (0 to 7) that selects a divide by 2^n ahead of the counter. It is captured only while the watchdog is disarmed. Changes made while armed have no effect until after the next reset.
- R7: Each timeout pulse holds `sys_rst` high for exactly 96 clock cycles.
- R8: From the timeout onward, the enable, the counter, the prescaler and any pending 0x1E are cleared. After the pulse, only a complete new key sequence arms the watchdog.
- R9: Writes made while `sys_rst` is high are ignored, including a complete key sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; it also times the reset pulse |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | Machine-cycle enable, one count opportunity per high cycle |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| presc_sel | input | 3 | Prescaler exponent n, divide by 2^n |
| sys_rst | output | 1 | Active-high system reset pulse |

## Verification
Every result in this block is due at a fixed edge counted from the edge that accepted the last key. The pulse rises 16383·2^n + 1 edges later, plus one edge for each cycle with `tick` held low, and it stays high for 96 cycles. The driver records the index of the accepting edge and queues the expected rise edge. The monitor samples `sys_rst` on falling edges, takes the edge count at the rise and counts the high cycles, then compares both against the queue. Checks that nothing happens, such as broken key sequences, writes during the pulse or a lone second key, wait longer than one full timeout before confirming that no pulse appeared.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KEY_ADDR_DEF   = 8'hA6;
  localparam logic [7:0] KEY_FIRST_DEF  = 8'h1E;
  localparam logic [7:0] KEY_SECOND_DEF = 8'hE1;
  localparam int         PULSE_LEN_DEF  = 96;

  // bits needed to encode an exponent from 0 up to the stage count
  function automatic int sel_width(input int stages);
    return $clog2(stages + 1);
  endfunction
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = '0,
  parameter logic [DATA_W-1:0] KEY_FIRST  = '0,
  parameter logic [DATA_W-1:0] KEY_SECOND = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              key_ok
);
  logic half_key;
  logic hit;

  // writes elsewhere, or during a clear, leave the detector untouched
  assign hit    = wr_en && (wr_addr == KEY_ADDR) && !clr;
  assign key_ok = hit && half_key && (wr_data == KEY_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   half_key <= 1'b0;
    else if (clr) half_key <= 1'b0;
    else if (hit) half_key <= (wr_data == KEY_FIRST);
  end

  // R9
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !key_ok);
endmodule

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
  parameter int PRE_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             en,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel_in,
  output logic             step
);
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  // low n bits of the mask set: step when they are all ones
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (SEL_W'(i) < sel_q);
  end

  assign step = en && tick && ((pcnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pcnt  <= '0;
    end else begin
      if (!en) sel_q <= sel_in;
      if (clr || restart || !en) pcnt <= '0;
      else if (tick)             pcnt <= pcnt + 1'b1;
    end
  end

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr |=> $stable(sel_q));
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic restart,
  input  logic step,
  output logic en,
  output logic ovf
);
  logic [CNT_W-1:0] cnt;

  assign ovf = en && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (clr)     en <= 1'b0;
    else if (restart) en <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || restart)   cnt <= '0;
    else if (step)             cnt <= cnt + 1'b1;
  end

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr |=> en);
  // R5
  service_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> en && (cnt == '0));
  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clr && !restart && !step |=> $stable(cnt));
  // R8
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !en && (cnt == '0));
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      len    <= '0;
    end else if (active) begin
      if (len == PW'(PULSE_LEN - 1)) begin
        active <= 1'b0;
        len    <= '0;
      end else begin
        len <= len + 1'b1;
      end
    end else if (start) begin
      active <= 1'b1;
      len    <= '0;
    end
  end

  // independent high-time counter for the width check
  logic [PW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (active) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  // R7
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> hi_cnt == PW'(PULSE_LEN));
  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !active |=> active);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog import wdk_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 14,
  parameter int PRE_W     = 7,
  parameter int PULSE_LEN = PULSE_LEN_DEF,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'(KEY_ADDR_DEF),
  parameter logic [DATA_W-1:0] KEY_FIRST  = DATA_W'(KEY_FIRST_DEF),
  parameter logic [DATA_W-1:0] KEY_SECOND = DATA_W'(KEY_SECOND_DEF),
  localparam int SEL_W = sel_width(PRE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  presc_sel,
  output logic              sys_rst
);
  logic key_ok, step, en, ovf, clr;

  // timeout and the whole pulse hold every other piece cleared
  assign clr = ovf || sys_rst;

  wdk_keyseq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_keyseq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .key_ok(key_ok)
  );

  wdk_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(key_ok), .en(en),
    .tick(tick), .sel_in(presc_sel), .step(step)
  );

  wdk_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr), .restart(key_ok),
    .step(step), .en(en), .ovf(ovf)
  );

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(ovf), .active(sys_rst)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !sys_rst |=> !sys_rst);
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_MAX    = 16383;
  localparam int PULSE      = 96;
  localparam int WD_LIMIT   = 195000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] presc_sel = '0;
  logic       sys_rst;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .presc_sel(presc_sel),
    .sys_rst(sys_rst)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int errors = 0;
  int checks = 0;
  int exp_rise[$];
  int seen_pulses = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measure rise edge and width, compare with the queue
  bit prev = 1'b0;
  int rise_at = 0;
  int width = 0;
  always @(negedge clk) begin
    int e;
    if (sys_rst && !prev) rise_at = pe;
    if (sys_rst) width++;
    if (!sys_rst && prev) begin
      seen_pulses++;
      if (exp_rise.size() == 0) begin
        check(1'b0, "R2 unexpected pulse at edge", rise_at, -1);
      end else begin
        e = exp_rise.pop_front();
        check(rise_at == e, "R4 pulse rise edge", rise_at, e);
        check(width == PULSE, "R7 pulse width", width, PULSE);
      end
      width = 0;
    end
    prev = sys_rst;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int edge_idx);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    edge_idx = pe;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", pe, WD_LIMIT);
    summary();
  end

  initial begin
    int k, d, exp;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sys_rst == 1'b0, "R1 sys_rst in reset", sys_rst, 0);
    rst_n = 1'b1;
    idle(5);
    check(sys_rst == 1'b0, "R1 sys_rst after reset", sys_rst, 0);

    // R2: broken sequences must not arm
    wr(8'hA6, 8'hE1, d);
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'h55, d); wr(8'hA6, 8'hE1, d);
    wr(8'hA6, 8'h1E, d); wr(8'h37, 8'hE1, d); wr(8'hA6, 8'h00, d);
    idle(16600);
    check(seen_pulses == 0, "R2 broken key sequences armed", seen_pulses, 0);

    // R2/R3/R4/R6/R7/R8/R9: arm, stall tick, junk writes, pulse
    presc_sel = 3'd0;
    wr(8'hA6, 8'h1E, d);
    wr(8'h10, 8'h5A, d);
    wr(8'hA6, 8'hE1, k);
    exp = k + CNT_MAX + 1 + 1000;
    exp_rise.push_back(exp);
    idle(3000);
    @(negedge clk); tick = 1'b0;
    repeat (1000) @(negedge clk);
    tick = 1'b1;
    wr(8'hA6, 8'h00, d);   // R3 junk write must not disarm
    presc_sel = 3'd7;      // R6 ignored while armed
    while (pe < exp - 6) @(negedge clk);
    wr(8'hA6, 8'h1E, d);   // R8 pending first key before timeout
    check(sys_rst == 1'b0, "R4 no early pulse", sys_rst, 0);
    while (!sys_rst) @(negedge clk);
    wr(8'hA6, 8'h1E, d);   // R9 full key during pulse
    wr(8'hA6, 8'hE1, d);
    while (sys_rst) @(negedge clk);
    wr(8'hA6, 8'hE1, d);   // R8 lone second key after pulse
    idle(16600);
    check(seen_pulses == 1, "R8 R9 re-armed without fresh key", seen_pulses, 1);

    // R5: services restart the count
    presc_sel = 3'd0;
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'hE1, k);
    idle(8000);
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'hE1, k);
    idle(8000);
    check(sys_rst == 1'b0, "R5 serviced watchdog quiet", sys_rst, 0);
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'hE1, k);
    exp_rise.push_back(k + CNT_MAX + 1);
    while (seen_pulses < 2) @(negedge clk);
    idle(2);
    check(seen_pulses == 2, "R5 pulse count after service", seen_pulses, 2);

    // R6: divide by 4, service also clears prescaler
    presc_sel = 3'd2;
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'hE1, k);
    idle(3001);
    wr(8'hA6, 8'h1E, d); wr(8'hA6, 8'hE1, k);
    exp_rise.push_back(k + (CNT_MAX << 2) + 1);
    while (seen_pulses < 3) @(negedge clk);
    idle(2);
    check(exp_rise.size() == 0, "R6 expected pulses outstanding", exp_rise.size(), 0);
    check(sys_rst == 1'b0, "R8 sys_rst low after final pulse", sys_rst, 0);
    summary();
  end
endmodule